// File: doc/BRIEF.md
# Masked Content Addressable Memory

This block is a small associative store. It holds a fixed number of data words, and each word has its own valid flag. A search offers a pattern and a mask word. Every valid entry is compared with the pattern at the same time. Only the bit positions the mask sets take part in the compare.

The result is registered. One clock after the search strobe, a hit flag reports whether any entry agreed. On a hit, the full stored word and its index are loaded into an output buffer. When several entries agree, a fixed-priority resolver picks the one with the lowest index. Entries are loaded through a simple write port. Writing an entry marks it valid.

Top module: `masked_cam`

## Requirements
- R1: After reset, `hit` is low, `hitIdx` and `hitData` are zero, and every entry is invalid, so a search with any pattern and mask misses.
- R2: A cycle with `wrEn` high stores `wrData` in entry `wrIdx` and marks that entry valid. Rewriting an entry replaces its word.
- R3: A stored bit is compared only where `srchMask` holds a 1. Bit positions where the mask is 0 never affect the outcome.
- R4: An invalid entry never matches, whatever the pattern and mask.
- R5: `hit` is registered. It is high exactly in the cycle after a cycle with `srchEn` high in which at least one valid entry matched. It is low after any cycle without `srchEn`.
- R6: When several valid entries match, the one with the lowest index is reported.
- R7: On a hit, `hitIdx` takes the index of the selected entry and `hitData` takes that entry's complete stored word, including bits the mask ignored. Both appear one cycle after the search.
- R8: A search that misses drives `hit` low and leaves `hitIdx` and `hitData` unchanged. Cycles without a search also leave them unchanged.
- R9: If a write and a search occur in the same cycle, the search uses the contents and valid flag the entry held before that write.
- R10: A search with an all-zero mask matches every valid entry, so it reports the lowest-indexed valid entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one entry |
| wrIdx | input | IDX_W | Entry to write |
| wrData | input | DATA_W | Word to store |
| srchEn | input | 1 | Search strobe |
| srchPattern | input | DATA_W | Pattern to look up |
| srchMask | input | DATA_W | 1 = bit position is compared |
| hit | output | 1 | Registered hit status of the previous cycle's search |
| hitIdx | output | IDX_W | Index of the selected matching entry |
| hitData | output | DATA_W | Stored word of the selected matching entry |

## Verification
The assertions assume that `wrIdx` always names an existing entry, and that `srchPattern` and `srchMask` carry defined values whenever `srchEn` is high. They also assume that all inputs are steady around the rising edge. The stimulus uses the default power-of-two depth, so every index value is legal. It changes inputs only on the falling edge and always drives pattern and mask with known values. Stored words and patterns come from a narrow value range, so that repeated and overlapping matches occur often under random masks.

// File: rtl/cam_pkg.sv
package cam_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic wrStrobe;   // store wrData into the addressed entry
    logic loadOut;    // capture the resolved entry into the output buffer
  } camCtrl_t;
endpackage

// File: rtl/cam_resolver.sv
module cam_resolver #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] reqVec,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyReq
);
  // Lowest index wins: scan from the top so the last assignment is the lowest
  always_comb begin
    grantIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (reqVec[i]) grantIdx = IDX_W'(i);
    end
    anyReq = |reqVec;
  end
endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  camCtrl_t          ctrl,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] srchPattern,
  input  logic [DATA_W-1:0] srchMask,
  output logic              matchAny,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData
);
  logic [DATA_W-1:0] entryMem [DEPTH];
  logic [DEPTH-1:0]  validVec;
  logic [DEPTH-1:0]  matchVec;
  logic [IDX_W-1:0]  grantIdx;

  // Parallel masked comparators, one per entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign matchVec[g] = validVec[g] &&
                         (((entryMem[g] ^ srchPattern) & srchMask) == '0);
  end

  cam_resolver #(.DEPTH(DEPTH), .IDX_W(IDX_W)) resolver_i (
    .reqVec  (matchVec),
    .grantIdx(grantIdx),
    .anyReq  (matchAny)
  );

  // Storage words carry no reset; the valid flags guard them
  always_ff @(posedge clk) begin
    if (ctrl.wrStrobe && (int'(wrIdx) < DEPTH)) entryMem[wrIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validVec <= '0;
    end else if (ctrl.wrStrobe && (int'(wrIdx) < DEPTH)) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  // Output buffer: the old entry contents are read, so a same-cycle write is not seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hitIdx  <= '0;
      hitData <= '0;
    end else if (ctrl.loadOut) begin
      hitIdx  <= grantIdx;
      hitData <= entryMem[grantIdx];
    end
  end

  // Assertion support: entries below the reported index
  logic [DEPTH-1:0] belowHit;
  always_comb begin
    for (int i = 0; i < DEPTH; i++) belowHit[i] = (i < int'(hitIdx));
  end

  // R3 / R7: the buffered word agrees with the search pattern on every masked bit
  a_r3_masked_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadOut |=> (((hitData ^ $past(srchPattern)) & $past(srchMask)) == '0));

  // R6: no entry below the reported index matched the search
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadOut |=> (($past(matchVec) & belowHit) == '0));

  // R8: the buffer holds its value when nothing is loaded
  a_r8_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.loadOut |=> ($stable(hitData) && $stable(hitIdx)));

  // R4: a load is only requested while some entry matches
  a_r4_load_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.loadOut |-> matchAny);
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrEn,
  input  logic     srchEn,
  input  logic     matchAny,
  output camCtrl_t ctrl,
  output logic     hit
);
  always_comb begin
    ctrl.wrStrobe = wrEn;
    ctrl.loadOut  = srchEn && matchAny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= srchEn && matchAny;
  end

  // R5: no search, no hit in the following cycle
  a_r5_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !srchEn |=> !hit);

  // R5 / R8: a search that finds nothing reports a miss
  a_r8_miss_low: assert property (@(posedge clk) disable iff (!rst_n)
    (srchEn && !matchAny) |=> !hit);

  // R5: a search that finds a match reports a hit
  a_r5_match_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (srchEn && matchAny) |=> hit);
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              srchEn,
  input  logic [DATA_W-1:0] srchPattern,
  input  logic [DATA_W-1:0] srchMask,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [DATA_W-1:0] hitData
);
  camCtrl_t ctrl;
  logic     matchAny;

  cam_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .srchEn  (srchEn),
    .matchAny(matchAny),
    .ctrl    (ctrl),
    .hit     (hit)
  );

  cam_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .wrIdx      (wrIdx),
    .wrData     (wrData),
    .srchPattern(srchPattern),
    .srchMask   (srchMask),
    .matchAny   (matchAny),
    .hitIdx     (hitIdx),
    .hitData    (hitData)
  );
endmodule

// File: tb/masked_cam_tb_top.sv
`timescale 1ns/1ps
module masked_cam_tb_top;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 8;
  localparam int IDX_W  = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wrEn;
  logic [IDX_W-1:0]  wrIdx;
  logic [DATA_W-1:0] wrData;
  logic              srchEn;
  logic [DATA_W-1:0] srchPattern;
  logic [DATA_W-1:0] srchMask;
  logic              hit;
  logic [IDX_W-1:0]  hitIdx;
  logic [DATA_W-1:0] hitData;

  always #2.5 clk = ~clk;

  masked_cam #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .srchEn(srchEn), .srchPattern(srchPattern), .srchMask(srchMask),
    .hit(hit), .hitIdx(hitIdx), .hitData(hitData)
  );

  int checks = 0;
  int failures = 0;

  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DEPTH-1:0]  refValid;
  logic [IDX_W-1:0]  expIdx;
  logic [DATA_W-1:0] expData;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Model: lowest valid entry agreeing on masked bits, -1 when none
  function automatic int refLookup(logic [DATA_W-1:0] pat, logic [DATA_W-1:0] msk);
    for (int i = 0; i < DEPTH; i++) begin
      if (refValid[i] && (((refMem[i] ^ pat) & msk) == '0)) return i;
    end
    return -1;
  endfunction

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic doCycle(string tag, bit w, int wi, logic [DATA_W-1:0] wd,
                         bit s, logic [DATA_W-1:0] pat, logic [DATA_W-1:0] msk);
    int found;
    bit expHit;
    wrEn = w; wrIdx = IDX_W'(wi); wrData = wd;
    srchEn = s; srchPattern = pat; srchMask = msk;
    found  = s ? refLookup(pat, msk) : -1;   // model state before the write (R9)
    expHit = (found >= 0);
    if (expHit) begin
      expIdx  = IDX_W'(found);
      expData = refMem[found];
    end
    @(posedge clk);
    if (w) begin
      refMem[wi]   = wd;
      refValid[wi] = 1'b1;
    end
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
    chk(tag, "hit", 32'(hit), 32'(expHit));
    chk(tag, "hitIdx", 32'(hitIdx), 32'(expIdx));
    chk(tag, "hitData", 32'(hitData), 32'(expData));
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wrEn = 1'b0; wrIdx = '0; wrData = '0;
    srchEn = 1'b0; srchPattern = '0; srchMask = '0;
    refValid = '0; expIdx = '0; expData = '0;
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of the outputs
    chk("R1", "hit after reset", 32'(hit), 32'd0);
    chk("R1", "hitIdx after reset", 32'(hitIdx), 32'd0);
    chk("R1", "hitData after reset", 32'(hitData), 32'd0);
    // R1 / R4: everything invalid, so even a zero mask misses
    doCycle("R1", 1'b0, 0, '0, 1'b1, 16'h0000, 16'h0000);

    // R2: write two equal words, R6: the lower index wins
    doCycle("R2", 1'b1, 5, 16'h1234, 1'b0, '0, '0);
    doCycle("R2", 1'b1, 2, 16'h1234, 1'b0, '0, '0);
    doCycle("R6", 1'b0, 0, '0, 1'b1, 16'h1234, 16'hFFFF);
    // R5: the idle cycle after a hit shows hit low
    doCycle("R5", 1'b0, 0, '0, 1'b0, 16'h1234, 16'hFFFF);
    // R3 / R7: low byte ignored, full stored word returned
    doCycle("R3", 1'b1, 6, 16'h56AB, 1'b0, '0, '0);
    doCycle("R3", 1'b0, 0, '0, 1'b1, 16'h56FF, 16'hFF00);
    chk("R7", "full word returned", 32'(hitData), 32'h56AB);
    // R8: a miss keeps the buffer
    doCycle("R8", 1'b0, 0, '0, 1'b1, 16'h9999, 16'hFFFF);
    chk("R8", "buffer kept on miss", 32'(hitData), 32'h56AB);
    // R4: entry 7 was never written and must not match its stale contents
    doCycle("R4", 1'b0, 0, '0, 1'b1, 16'h0000, 16'hFFFF);
    // R9: write and search the same entry in one cycle
    doCycle("R9", 1'b1, 0, 16'hAAAA, 1'b1, 16'hAAAA, 16'hFFFF);
    doCycle("R9", 1'b0, 0, '0, 1'b1, 16'hAAAA, 16'hFFFF);
    chk("R9", "new word found next", 32'(hitIdx), 32'd0);
    // R2: rewrite replaces the word
    doCycle("R2", 1'b1, 0, 16'h0F0F, 1'b0, '0, '0);
    doCycle("R2", 1'b0, 0, '0, 1'b1, 16'hAAAA, 16'hFFFF);
    // R10: zero mask picks the lowest valid entry
    doCycle("R10", 1'b0, 0, '0, 1'b1, 16'hDEAD, 16'h0000);

    // Random mix, narrow value range to provoke matches (R3, R6, R7, R8, R9)
    for (int n = 0; n < 400; n++) begin
      bit w = ($urandom % 3) == 0;
      bit s = ($urandom % 4) != 0;
      int wi = int'($urandom % DEPTH);
      logic [DATA_W-1:0] wd  = DATA_W'($urandom % 8);
      logic [DATA_W-1:0] pat = DATA_W'($urandom % 8);
      logic [DATA_W-1:0] msk = DATA_W'($urandom);
      doCycle("R7", w, wi, wd, s, pat, msk);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule